// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is the only master on a two-wire serial bus. Software moves the bus one byte at a time through five registers: a clock divider, a control register, a status register, a transmit byte and a receive byte. A write to the transmit byte register is the trigger. It launches a transfer and drops the completion flag at once.

Each transfer clocks eight bits out most significant bit first, or samples eight bits in. A ninth clock then carries the acknowledge. A start or repeated start can come before the byte, and a stop can follow it. Both are requested through control bits and cleared by hardware when it acts on them.

Longer sequences are built by software from these single-byte steps. Examples are an address byte followed by data bytes, or a repeated start followed by reads. SCL and SDA are open-drain: each output-enable pulls its line low, and SDA is read back from the wired line.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, status reads 0x01 (complete=1, no-ack=0), control reads 0x00, and both scl_oe and sda_oe are 0.
- R2: Register addresses are 0 = divider, 1 = control, 2 = status, 3 = transmit byte, 4 = receive byte. Control bits are: bit0 enable, bit1 start, bit2 stop, bit3 read, bit4 master-NACK. Status bits are: bit0 complete, bit1 no-ack. The divider and control registers read back what was written.
- R3: A write to address 3 while enable=1 and complete=1 starts a byte transfer. Complete reads 0 from the next cycle until that byte, including any stop, has finished.
- R4: A write to address 3 while enable=0, or while complete=0, has no effect: complete stays as it was, no start is issued, and the byte in flight is not changed.
- R5: When the bus is free, or the start bit is set at launch, SDA falls while SCL is high before the first bit. The start bit reads 0 after launch.
- R6: Bits leave most significant first. Outside start and stop, sda_oe does not change while SCL stays released.
- R7: With divider value P (0 behaves as 1), each SCL bit period is 2*P clock cycles, P low and P high.
- R8: On a write byte the ninth clock leaves SDA released, and the sampled line is stored in status bit1 (1 = not acknowledged).
- R9: On a read byte SDA is released for eight bits. The byte appears at address 4 when complete sets. On the ninth clock the master pulls SDA low for ACK, or releases it for NACK when control bit4 is 1.
- R10: With the stop bit set, the byte is followed by SDA rising while SCL is high. Both lines are then released, complete sets, and the stop bit reads 0.
- R11: Without stop, SCL is held low after the byte. A following byte launched without the start bit issues no start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Wired SDA line level |

## Verification
The bench uses the default 8-bit divider width and sweeps the divider over 0, 1, 2 and 3. This covers the zero-as-one rule, the tightest single-cycle half period, and the bit-period arithmetic. At divider 1 every one of the 256 byte values is sent after an address byte. A bench slave decodes each byte from the lines and compares it with the written value. The sweep also covers slave NACK, repeated start, and reads closed by ACK and by NACK plus stop, so every state path of the sequencer is taken under each divider.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int PW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_RS, S_ST, S_BIT, S_SP} st_t;

  st_t           state;
  logic [PW-1:0] presc, cnt;
  logic [4:0]    ph;
  logic          en, c_start, c_stop, c_rd, c_nack;
  logic          op_stop, op_rd, op_nack, nak;
  logic [7:0]    sh, rxd;

  wire           done   = (state == S_IDLE) || (state == S_HOLD);
  wire [PW-1:0]  pmax   = (presc == '0) ? '0 : presc - 1'b1;
  wire           tick   = !done && (cnt == pmax);
  wire           launch = reg_we && (reg_addr == 3'd3) && en && done;
  wire [3:0]     bidx   = ph[4:1];
  wire           bit_val = (bidx == 4'd8) ? (op_rd ? op_nack : 1'b1)
                                          : (op_rd ? 1'b1 : sh[7]);

  always_comb begin
    case (state)
      S_HOLD:  begin scl_oe = 1'b1;            sda_oe = 1'b0;     end
      S_RS:    begin scl_oe = (ph == 5'd0);    sda_oe = 1'b0;     end
      S_ST:    begin scl_oe = 1'b0;            sda_oe = 1'b1;     end
      S_BIT:   begin scl_oe = !ph[0];          sda_oe = !bit_val; end
      S_SP:    begin scl_oe = (ph == 5'd0);    sda_oe = 1'b1;     end
      default: begin scl_oe = 1'b0;            sda_oe = 1'b0;     end
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 8'(presc);
      3'd1:    reg_rdata = {3'b000, c_nack, c_rd, c_stop, c_start, en};
      3'd2:    reg_rdata = {6'b0, nak, done};
      3'd4:    reg_rdata = rxd;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      presc <= '0;
      cnt <= '0;
      ph <= '0;
      {en, c_start, c_stop, c_rd, c_nack} <= '0;
      {op_stop, op_rd, op_nack, nak} <= '0;
      sh <= '0;
      rxd <= '0;
    end else begin
      if (reg_we && reg_addr == 3'd0) presc <= PW'(reg_wdata);
      if (reg_we && reg_addr == 3'd1)
        {c_nack, c_rd, c_stop, c_start, en} <= reg_wdata[4:0];
      if (launch) begin
        op_stop <= c_stop;
        op_rd   <= c_rd;
        op_nack <= c_nack;
        c_start <= 1'b0;
        c_stop  <= 1'b0;
        sh      <= c_rd ? 8'hFF : reg_wdata;
        cnt     <= '0;
        ph      <= '0;
        state   <= (state == S_IDLE) ? S_ST : (c_start ? S_RS : S_BIT);
      end else if (!done) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          case (state)
            S_RS: if (ph == 5'd1) begin state <= S_ST; ph <= '0; end
                  else ph <= ph + 5'd1;
            S_ST: begin state <= S_BIT; ph <= '0; end
            S_BIT: begin
              if (ph[0]) begin
                if (bidx != 4'd8) sh <= {sh[6:0], sda_in};
                else begin
                  nak <= op_rd ? 1'b0 : sda_in;
                  if (op_rd) rxd <= sh;
                end
              end
              if (ph == 5'd17) begin
                state <= op_stop ? S_SP : S_HOLD;
                ph <= '0;
              end else ph <= ph + 5'd1;
            end
            S_SP: if (ph == 5'd1) state <= S_IDLE;
                  else ph <= ph + 5'd1;
            default: ;
          endcase
        end
      end
    end
  end

  // R6
  sda_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT && $past(state) == S_BIT && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));

  // R3
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && en && done) |=> !done);

  // R5
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && en && done) |=> !c_start);

  // R4
  ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd3 && !en && done) |=> done);

  // R10
  stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && $past(state) == S_SP) |-> ($past(sda_oe) && !$past(scl_oe)));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic scl_oe, sda_oe, sda_in;
  logic pull = 0;
  wire scl_l = !scl_oe;
  wire sda_l = !sda_oe && !pull;
  assign sda_in = sda_l;

  i2c_byte_master dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in));

  always #2 clk = !clk;

  int total = 0, bad = 0;
  bit finished = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  logic psc = 1, psd = 1, mack = 0, rd_mode = 0, ack_en = 1, rd_quiet = 0;
  logic [7:0] got = 0, last_byte = 0, rd_byte = 0;
  int bitn = 0, start_cnt = 0, stop_cnt = 0, per_err = 0, per_cnt = 0, pexp = 1;
  longint last_rise = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (psc && scl_l && psd && !sda_l) begin start_cnt++; bitn = 0; rd_quiet = 0; end
      else if (psc && scl_l && !psd && sda_l) stop_cnt++;
      if (!psc && scl_l) begin
        if (bitn >= 1 && bitn <= 8) begin
          per_cnt++;
          if (cyc - last_rise != longint'(2 * pexp)) per_err++;
        end
        last_rise = cyc;
        if (bitn < 8) begin
          got = {got[6:0], sda_l};
          if (bitn == 7) last_byte = got;
        end else begin
          mack = sda_l;
          if (rd_mode && sda_l) rd_quiet = 1;
        end
        bitn = (bitn == 8) ? 0 : bitn + 1;
      end
      psc = scl_l;
      psd = sda_l;
      if (!scl_l)
        pull = (!rd_mode && bitn == 8 && ack_en) ||
               (rd_mode && !rd_quiet && bitn < 8 && !rd_byte[3'(7 - bitn)]);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done;
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd2, s);
      if (s[0]) return;
      @(negedge clk);
    end
    chk(0, "R3 completion timeout", 0, 1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] v, a;
    int s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd2, v); chk(v == 8'h01, "R1 status", v, 8'h01);
    rd(3'd1, v); chk(v == 8'h00, "R1 control", v, 0);
    chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

    wr(3'd0, 8'h05); rd(3'd0, v); chk(v == 8'h05, "R2 divider readback", v, 5);
    wr(3'd1, 8'h1C); rd(3'd1, v); chk(v == 8'h1C, "R2 control readback", v, 8'h1C);

    wr(3'd1, 8'h00); s0 = start_cnt;
    wr(3'd3, 8'hA5);
    repeat (20) @(negedge clk);
    rd(3'd2, v); chk(v[0] == 1'b1, "R4 disabled write keeps complete", v[0], 1);
    chk(start_cnt == s0 && !scl_oe, "R4 disabled write no start", start_cnt - s0, 0);

    for (int p = 0; p < 4; p++) begin
      pexp = (p == 0) ? 1 : p;
      per_err = 0; per_cnt = 0;
      wr(3'd0, 8'(p));
      ack_en = 1; rd_mode = 0;
      a = 8'hA0 | 8'(p << 1);
      wr(3'd1, 8'h03); s0 = start_cnt;
      wr(3'd3, a);
      rd(3'd2, v); chk(v[0] == 1'b0, "R3 complete clears", v[0], 0);
      wr(3'd3, 8'h55);
      wait_done();
      chk(last_byte == a, "R6 address byte (R4 busy write ignored)", last_byte, a);
      chk(start_cnt == s0 + 1, "R5 start issued", start_cnt - s0, 1);
      rd(3'd1, v); chk(v == 8'h01, "R5 start bit self-clears", v, 1);
      rd(3'd2, v); chk(v[1] == 1'b0, "R8 ack recorded", v[1], 0);
      chk(scl_oe == 1'b1, "R11 SCL held low", scl_oe, 1);

      for (int k = 0; k < ((p == 1) ? 256 : 8); k++) begin
        logic [7:0] d;
        d = (p == 1) ? 8'(k) : 8'(k * 37 + p * 11);
        s0 = start_cnt;
        wr(3'd3, d);
        wait_done();
        chk(last_byte == d, "R6 data byte", last_byte, d);
        chk(start_cnt == s0, "R11 no start between bytes", start_cnt - s0, 0);
      end

      ack_en = 0;
      wr(3'd3, 8'h3C); wait_done();
      rd(3'd2, v); chk(v[1] == 1'b1, "R8 no-ack recorded", v[1], 1);
      ack_en = 1;

      wr(3'd1, 8'h03); s0 = start_cnt;
      wr(3'd3, a | 8'h01); wait_done();
      chk(start_cnt == s0 + 1, "R5 repeated start", start_cnt - s0, 1);
      chk(last_byte == (a | 8'h01), "R6 read address", last_byte, a | 8'h01);

      rd_mode = 1; rd_byte = 8'h96 ^ 8'(p * 29);
      wr(3'd1, 8'h09);
      wr(3'd3, 8'h00); wait_done();
      rd(3'd4, v); chk(v == rd_byte, "R9 read byte", v, rd_byte);
      chk(mack == 1'b0, "R9 master ACK", mack, 0);
      rd(3'd2, v); chk(v[1] == 1'b0, "R9 no-ack clear on read", v[1], 0);

      rd_byte = 8'h3B + 8'(p * 71); p0 = stop_cnt;
      wr(3'd1, 8'h1D);
      wr(3'd3, 8'h00); wait_done();
      rd(3'd4, v); chk(v == rd_byte, "R9 read byte before stop", v, rd_byte);
      chk(mack == 1'b1, "R9 master NACK", mack, 1);
      chk(stop_cnt == p0 + 1, "R10 stop condition", stop_cnt - p0, 1);
      chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
      rd(3'd1, v); chk(v == 8'h19, "R10 stop bit self-clears", v, 8'h19);
      rd_mode = 0;
      wr(3'd1, 8'h00);

      chk(per_err == 0 && per_cnt > 0, "R7 SCL period", per_err, 0);
    end
    finish_run();
  end
endmodule